// File: doc/BRIEF.md
# Peripheral Bus Transfer Monitor with Cadence Checking

This block sits beside a two-phase peripheral bus (APB-style: select, enable, ready, address, direction, write data). It drives nothing on the bus. Every cycle it sorts the bus into one of four phases: idle, setup, waiting access or completing access. It then checks that only one transfer is in flight at any time. The checks cover phase overlap, phase ordering, entry into the access phase, and the stability of address and control across a transfer. For each transfer it counts the cycles and the wait cycles, checks that the transfer cost exactly two cycles plus its waits, and reports the wait count when the transfer finishes.

A free-running window of `WIN_LEN` cycles gathers the number of completions and the total number of wait cycles. At the end of each window the totals are latched onto outputs. A cadence fault is raised when a window holds more completions than half its length, which is faster than one transfer every two cycles. All fault flags are sticky until `clr_i` pulses.

Both reports are valid-only streams with no ready input. A watcher that is not ready loses the report, because a passive monitor cannot stall the bus it observes. `WIN_LEN` should be even. With an odd window, a legal back-to-back stream that starts in mid-window can exceed the half-length bound by one.

Top module: `apb_cadence_mon`

## Requirements
- R1: While `rst_ni` is low, and after it rises, every bit of `err_o`, `xfer_vld_o`, `win_vld_o`, `win_cmpl_o` and `win_waits_o` is zero.
- R2: If a cycle with select, enable high and ready low is followed by a cycle with select high and enable low, fault bit 0 (overlap) of `err_o` is set from the next cycle.
- R3: If a setup cycle (select high, enable low) is followed by anything other than an access cycle (select and enable high), fault bit 1 (ordering) is set from the next cycle.
- R4: If an access cycle follows something other than a setup cycle or a waiting access cycle, fault bit 2 (entry) is set from the next cycle.
- R5: If address, direction or write data in a legally entered access cycle differ from the values seen in that transfer's setup cycle, fault bit 3 (hold) is set from the next cycle.
- R6: In the cycle after each completion (select, enable and ready all high), `xfer_vld_o` is high for one cycle. At the same time `xfer_waits_o` holds that transfer's count of ready-low access cycles. Back-to-back transfers with no idle cycle between them raise no fault.
- R7: If a completing transfer's cycle count from its setup cycle differs from two plus its wait count, fault bit 4 (cost) is set from the next cycle. An access that has no setup therefore trips this fault.
- R8: At the end of every `WIN_LEN` cycles after reset, `win_vld_o` pulses for one cycle. At the same time `win_cmpl_o` and `win_waits_o` show the completions and wait cycles of that window.
- R9: When twice a window's completion count exceeds `WIN_LEN`, fault bit 5 (cadence) is set together with that window's `win_vld_o`.
- R10: Fault bits stay set until `clr_i` is high for a cycle, which clears all of them from the next cycle. A fault raised in the same cycle as a clear stays set.
- R11: Dropping select while an access is waiting ends the transfer with no report and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Clears the sticky fault flags |
| bus_sel_i | input | 1 | Observed select |
| bus_enable_i | input | 1 | Observed enable (access phase marker) |
| bus_ready_i | input | 1 | Observed ready |
| bus_addr_i | input | AW | Observed address |
| bus_write_i | input | 1 | Observed direction |
| bus_wdata_i | input | DW | Observed write data |
| err_o | output | 6 | Sticky faults: 0 overlap, 1 ordering, 2 entry, 3 hold, 4 cost, 5 cadence |
| xfer_vld_o | output | 1 | Transfer report strobe |
| xfer_waits_o | output | WAIT_W | Wait cycles of the reported transfer |
| win_vld_o | output | 1 | Window report strobe |
| win_cmpl_o | output | CNT_W | Completions in the reported window |
| win_waits_o | output | CNT_W | Wait cycles in the reported window |

## Verification
The bench uses 8-bit address and data, a 4-bit wait counter and an 8-cycle window. These values keep every window boundary within a few stimulus rows, so a legal zero-wait burst fills a window exactly to its half-length bound. A stream with enable held high pushes a window to twice that bound. The short window also lets windows with and without waits be compared one after another, with the window phase set by a fresh reset.

// File: rtl/apb_mon_pkg.sv
package apb_mon_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_WAIT  = 2'd2,
    PH_DONE  = 2'd3
  } phase_e;

  localparam int unsigned N_FAULT   = 6;
  localparam int unsigned F_OVERLAP = 0;
  localparam int unsigned F_ORDER   = 1;
  localparam int unsigned F_ENTRY   = 2;
  localparam int unsigned F_HOLD    = 3;
  localparam int unsigned F_COST    = 4;
  localparam int unsigned F_CADENCE = 5;

  function automatic phase_e classify(input logic sel, input logic en, input logic rdy);
    if (!sel)     return PH_IDLE;
    else if (!en) return PH_SETUP;
    else if (!rdy) return PH_WAIT;
    else          return PH_DONE;
  endfunction

endpackage

// File: rtl/apb_mon_phase.sv
module apb_mon_phase
  import apb_mon_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        ph_i,
  input  logic [AW-1:0] addr_i,
  input  logic          write_i,
  input  logic [DW-1:0] wdata_i,
  output logic          overlap_o,
  output logic          order_o,
  output logic          entry_o,
  output logic          hold_o
);

  logic          prv_setup_q, prv_wait_q;
  logic [AW-1:0] cap_addr_q;
  logic          cap_write_q;
  logic [DW-1:0] cap_wdata_q;
  logic          cur_acc, entry_ok, ctl_moved;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prv_setup_q <= 1'b0;
      prv_wait_q  <= 1'b0;
      cap_addr_q  <= '0;
      cap_write_q <= 1'b0;
      cap_wdata_q <= '0;
    end else begin
      prv_setup_q <= (ph_i == PH_SETUP);
      prv_wait_q  <= (ph_i == PH_WAIT);
      if (ph_i == PH_SETUP) begin
        cap_addr_q  <= addr_i;
        cap_write_q <= write_i;
        cap_wdata_q <= wdata_i;
      end
    end
  end

  always_comb begin
    cur_acc   = (ph_i == PH_WAIT) || (ph_i == PH_DONE);
    entry_ok  = prv_setup_q || prv_wait_q;
    ctl_moved = (addr_i != cap_addr_q) || (write_i != cap_write_q) ||
                (wdata_i != cap_wdata_q);
    overlap_o = prv_wait_q && (ph_i == PH_SETUP);
    order_o   = prv_setup_q && !cur_acc;
    entry_o   = cur_acc && !entry_ok;
    hold_o    = cur_acc && entry_ok && ctl_moved;
  end

endmodule

// File: rtl/apb_mon_cost.sv
module apb_mon_cost
  import apb_mon_pkg::*;
#(
  parameter int unsigned WAIT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            ph_i,
  output logic              cost_o,
  output logic              vld_o,
  output logic [WAIT_W-1:0] waits_o
);

  localparam int unsigned          CYC_W    = WAIT_W + 1;
  localparam logic [WAIT_W-1:0]    WAIT_MAX = '1;

  logic [CYC_W-1:0]  cyc_q;
  logic [WAIT_W-1:0] wt_q;
  logic [CYC_W-1:0]  expect_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= '0;
      wt_q    <= '0;
      vld_o   <= 1'b0;
      waits_o <= '0;
    end else begin
      vld_o <= (ph_i == PH_DONE);
      if (ph_i == PH_DONE) waits_o <= wt_q;
      unique case (ph_i)
        PH_SETUP: begin
          cyc_q <= CYC_W'(1);
          wt_q  <= '0;
        end
        PH_WAIT: begin
          if (wt_q != WAIT_MAX) begin
            cyc_q <= cyc_q + 1'b1;
            wt_q  <= wt_q + 1'b1;
          end
        end
        default: begin
          cyc_q <= '0;
          wt_q  <= '0;
        end
      endcase
    end
  end

  // cycles so far exclude the completing cycle, so the rule 2 + w becomes 1 + w here
  always_comb begin
    expect_cyc = {1'b0, wt_q} + 1'b1;
    cost_o     = (ph_i == PH_DONE) && (cyc_q != expect_cyc);
  end

endmodule

// File: rtl/apb_mon_window.sv
module apb_mon_window #(
  parameter int unsigned WIN_LEN = 64,
  parameter int unsigned CNT_W   = $clog2(WIN_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmpl_i,
  input  logic             wait_i,
  output logic             cadence_o,
  output logic             vld_o,
  output logic [CNT_W-1:0] cmpl_o,
  output logic [CNT_W-1:0] waits_o
);

  localparam int unsigned        WC_W    = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WC_W-1:0]    WC_LAST = WC_W'(WIN_LEN - 1);
  localparam logic [CNT_W:0]     LIMIT   = (CNT_W + 1)'(WIN_LEN);

  logic [WC_W-1:0]  wc_q;
  logic [CNT_W-1:0] cc_q, ws_q, cc_nx, ws_nx;
  logic             last;

  always_comb begin
    last      = (wc_q == WC_LAST);
    cc_nx     = cc_q + CNT_W'(cmpl_i);
    ws_nx     = ws_q + CNT_W'(wait_i);
    cadence_o = last && ({cc_nx, 1'b0} > LIMIT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wc_q    <= '0;
      cc_q    <= '0;
      ws_q    <= '0;
      vld_o   <= 1'b0;
      cmpl_o  <= '0;
      waits_o <= '0;
    end else begin
      vld_o <= last;
      if (last) begin
        wc_q    <= '0;
        cc_q    <= '0;
        ws_q    <= '0;
        cmpl_o  <= cc_nx;
        waits_o <= ws_nx;
      end else begin
        wc_q <= wc_q + 1'b1;
        cc_q <= cc_nx;
        ws_q <= ws_nx;
      end
    end
  end

endmodule

// File: rtl/apb_cadence_mon.sv
module apb_cadence_mon
  import apb_mon_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned WAIT_W  = 8,
  parameter int unsigned WIN_LEN = 64,
  parameter int unsigned CNT_W   = $clog2(WIN_LEN + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                bus_sel_i,
  input  logic                bus_enable_i,
  input  logic                bus_ready_i,
  input  logic [AW-1:0]       bus_addr_i,
  input  logic                bus_write_i,
  input  logic [DW-1:0]       bus_wdata_i,
  output logic [N_FAULT-1:0]  err_o,
  output logic                xfer_vld_o,
  output logic [WAIT_W-1:0]   xfer_waits_o,
  output logic                win_vld_o,
  output logic [CNT_W-1:0]    win_cmpl_o,
  output logic [CNT_W-1:0]    win_waits_o
);

  phase_e             ph;
  logic [N_FAULT-1:0] hit;

  assign ph = classify(bus_sel_i, bus_enable_i, bus_ready_i);

  apb_mon_phase #(.AW(AW), .DW(DW)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ph_i      (ph),
    .addr_i    (bus_addr_i),
    .write_i   (bus_write_i),
    .wdata_i   (bus_wdata_i),
    .overlap_o (hit[F_OVERLAP]),
    .order_o   (hit[F_ORDER]),
    .entry_o   (hit[F_ENTRY]),
    .hold_o    (hit[F_HOLD])
  );

  apb_mon_cost #(.WAIT_W(WAIT_W)) u_cost (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ph_i    (ph),
    .cost_o  (hit[F_COST]),
    .vld_o   (xfer_vld_o),
    .waits_o (xfer_waits_o)
  );

  apb_mon_window #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmpl_i    (ph == PH_DONE),
    .wait_i    (ph == PH_WAIT),
    .cadence_o (hit[F_CADENCE]),
    .vld_o     (win_vld_o),
    .cmpl_o    (win_cmpl_o),
    .waits_o   (win_waits_o)
  );

  // sticky fault flags: a set in the same cycle as a clear wins
  for (genvar g = 0; g < N_FAULT; g++) begin : g_sticky
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) err_o[g] <= 1'b0;
      else         err_o[g] <= (err_o[g] && !clr_i) || hit[g];
    end
  end

endmodule

// File: rtl/apb_cadence_mon_chk.sv
module apb_cadence_mon_chk #(
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned WAIT_W  = 8,
  parameter int unsigned WIN_LEN = 64,
  parameter int unsigned CNT_W   = $clog2(WIN_LEN + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic              bus_sel_i,
  input logic              bus_enable_i,
  input logic              bus_ready_i,
  input logic [AW-1:0]     bus_addr_i,
  input logic              bus_write_i,
  input logic [DW-1:0]     bus_wdata_i,
  input logic [5:0]        err_o,
  input logic              xfer_vld_o,
  input logic [WAIT_W-1:0] xfer_waits_o,
  input logic              win_vld_o,
  input logic [CNT_W-1:0]  win_cmpl_o,
  input logic [CNT_W-1:0]  win_waits_o
);

  AST_OVERLAP_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && bus_enable_i && !bus_ready_i) ##1 (bus_sel_i && !bus_enable_i)
      |=> err_o[0]); // R2

  AST_ORDER_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && !bus_enable_i) ##1 !(bus_sel_i && bus_enable_i)
      |=> err_o[1]); // R3

  AST_REPORT_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_vld_o |-> $past(bus_sel_i && bus_enable_i && bus_ready_i)); // R6

  AST_WIN_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld_o |=> !win_vld_o); // R8

  AST_CADENCE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_vld_o && !err_o[5]) |-> ({1'b0, win_cmpl_o, 1'b0} <= (CNT_W + 2)'(WIN_LEN))); // R9

  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((err_o != 6'd0) && !clr_i) |=> ((err_o & $past(err_o)) == $past(err_o))); // R10

endmodule

bind apb_cadence_mon apb_cadence_mon_chk #(
  .AW(AW), .DW(DW), .WAIT_W(WAIT_W), .WIN_LEN(WIN_LEN), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/apb_cadence_mon_tb.sv
module apb_cadence_mon_tb;

  localparam int unsigned AW = 8, DW = 8, WAIT_W = 4, WIN_LEN = 8;
  localparam int unsigned CNT_W = $clog2(WIN_LEN + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0, clr_i = 1'b0;
  logic bus_sel_i = 1'b0, bus_enable_i = 1'b0, bus_ready_i = 1'b0, bus_write_i = 1'b0;
  logic [AW-1:0] bus_addr_i = '0;
  logic [DW-1:0] bus_wdata_i = '0;
  logic [5:0] err_o;
  logic xfer_vld_o, win_vld_o;
  logic [WAIT_W-1:0] xfer_waits_o;
  logic [CNT_W-1:0] win_cmpl_o, win_waits_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  apb_cadence_mon #(.AW(AW), .DW(DW), .WAIT_W(WAIT_W), .WIN_LEN(WIN_LEN)) u_dut (.*);

  // row: sel en rdy wr clr | addr nibble | err[4:0] {cost,hold,entry,order,overlap} | done | waits
  localparam int NROW = 27;
  localparam logic [18:0] TBL [NROW] = '{
    19'b0_0_0_1_0_0000_00000_0_0000, // idle
    19'b1_0_0_1_0_0001_00000_0_0000, // setup
    19'b1_1_1_1_0_0001_00000_1_0000, // R6 zero-wait completion
    19'b1_0_0_1_0_0010_00000_0_0000, // R6 back-to-back setup, legal
    19'b1_1_0_1_0_0010_00000_0_0000, // wait
    19'b1_1_0_1_0_0010_00000_0_0000, // wait
    19'b1_1_1_1_0_0010_00000_1_0010, // R6 R7 two waits reported, cost consistent
    19'b0_0_0_1_0_0000_00000_0_0000,
    19'b1_0_0_1_0_0011_00000_0_0000,
    19'b1_1_0_1_0_0011_00000_0_0000, // waiting access
    19'b1_0_0_1_0_0100_00001_0_0000, // R2 new setup during wait
    19'b1_1_1_1_0_0100_00001_1_0000, // R10 flag stays
    19'b0_0_0_1_1_0000_00000_0_0000, // R10 clear
    19'b1_0_0_1_0_0101_00000_0_0000,
    19'b1_0_0_1_0_0101_00010_0_0000, // R3 setup lasting two cycles
    19'b1_1_1_1_0_0101_00010_1_0000,
    19'b0_0_0_1_1_0000_00000_0_0000,
    19'b1_1_0_1_0_0101_00100_0_0000, // R4 access without setup
    19'b1_1_1_1_0_0101_10100_1_0001, // R7 cost mismatch
    19'b0_0_0_1_1_0000_00000_0_0000,
    19'b1_0_0_1_0_0110_00000_0_0000,
    19'b1_1_1_1_0_0111_01000_1_0000, // R5 address moved
    19'b0_0_0_1_1_0000_00000_0_0000,
    19'b1_0_0_1_0_1000_00000_0_0000,
    19'b1_1_0_0_0_1000_01000_0_0000, // R5 direction moved
    19'b0_0_0_1_0_0000_01000_0_0000, // R11 select dropped during wait
    19'b0_0_0_1_1_0000_00000_0_0000
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic e, input logic r, input logic w,
                      input logic c, input logic [AW-1:0] a);
    @(negedge clk_i);
    bus_sel_i = s; bus_enable_i = e; bus_ready_i = r; bus_write_i = w; clr_i = c;
    bus_addr_i = a; bus_wdata_i = a ^ 8'h5A;
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; clr_i = 1'b0;
    bus_sel_i = 1'b0; bus_enable_i = 1'b0; bus_ready_i = 1'b0;
    repeat (2) @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
  endtask

  task automatic chk_zero(input string tag);
    chk(err_o == 6'd0 && !xfer_vld_o && !win_vld_o && win_cmpl_o == '0 &&
        win_waits_o == '0 && xfer_waits_o == '0, tag,
        {err_o, xfer_vld_o, win_vld_o, win_cmpl_o}, 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    chk_zero("R1 after reset");

    for (int i = 0; i < NROW; i++) begin
      logic [18:0] v;
      v = TBL[i];
      step(v[18], v[17], v[16], v[15], v[14], {4'hA, v[13:10]});
      chk(err_o[4:0] == v[9:5], $sformatf("row %0d err", i), err_o[4:0], v[9:5]);
      chk(xfer_vld_o == v[4], $sformatf("row %0d report strobe", i), xfer_vld_o, v[4]);
      if (v[4]) chk(xfer_waits_o == v[3:0], $sformatf("row %0d waits", i), xfer_waits_o, v[3:0]);
      chk(err_o[5] == 1'b0, $sformatf("row %0d cadence", i), err_o[5], 0);
    end

    // R8 R9 window 1: zero-wait back-to-back fills the bound exactly
    do_reset();
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 0, 1, 0, 8'h20);
      if (k == 3) chk(win_vld_o == 1'b0, "R8 no strobe before window end", win_vld_o, 0);
      step(1, 1, 1, 1, 0, 8'h20);
    end
    chk(win_vld_o == 1'b1, "R8 window 1 strobe", win_vld_o, 1);
    chk(win_cmpl_o == 4, "R8 window 1 completions", win_cmpl_o, 4);
    chk(win_waits_o == 0, "R8 window 1 waits", win_waits_o, 0);
    chk(err_o == 6'd0, "R9 R6 legal burst no fault", err_o, 0);

    // R8 window 2: two transfers with two waits each
    for (int k = 0; k < 2; k++) begin
      step(1, 0, 0, 1, 0, 8'h30);
      step(1, 1, 0, 1, 0, 8'h30);
      if (k == 0) chk(win_vld_o == 1'b0, "R8 strobe single cycle", win_vld_o, 0);
      step(1, 1, 0, 1, 0, 8'h30);
      step(1, 1, 1, 1, 0, 8'h30);
    end
    chk(win_vld_o == 1'b1, "R8 window 2 strobe", win_vld_o, 1);
    chk(win_cmpl_o == 2, "R8 window 2 completions", win_cmpl_o, 2);
    chk(win_waits_o == 4, "R8 window 2 waits", win_waits_o, 4);
    chk(err_o == 6'd0, "R9 slow stream no fault", err_o, 0);

    // R9 window 3: enable held high, one completion per cycle
    for (int k = 0; k < 8; k++) step(1, 1, 1, 1, 0, 8'h30);
    chk(win_cmpl_o == 8, "R9 window 3 completions", win_cmpl_o, 8);
    chk(err_o[5] == 1'b1, "R9 cadence fault", err_o[5], 1);
    chk(err_o[2] == 1'b1, "R4 entry fault on held enable", err_o[2], 1);

    // R10 a quiet cycle keeps flags, clear removes them
    step(0, 0, 0, 1, 0, 8'h00);
    chk(err_o[5] == 1'b1, "R10 sticky cadence", err_o[5], 1);
    step(0, 0, 0, 1, 1, 8'h00);
    chk(err_o == 6'd0, "R10 clear", err_o, 0);

    // R1 reset with flags raised
    step(1, 0, 0, 1, 0, 8'h40);
    step(0, 0, 0, 1, 0, 8'h40);
    do_reset();
    chk_zero("R1 reset clears raised flags");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule